// File: doc/BRIEF.md
# Wake-up Source Mask and Cause Recorder

This block sits between the interrupt lines of seventeen peripheral slots and the power controller of a small system. Each slot has its own wake-up enable bit. While the CPU reports that it is in light sleep or in deep sleep, any enabled slot whose interrupt is active raises a wake request in the same cycle. The same interrupt-and-enable pattern is then latched into a sticky cause word. Software reads the cause word after resuming to learn which sources woke the system. It clears individual bits by writing ones to them.

Software reaches the block through a simple single-cycle register bus. There are three word locations. The first holds the enable mask. The second holds the cause word, which is cleared by writing ones. The third is a read-only view of the CPU sleep flags. The slot layout is shared by the mask and the cause word:

| Bit | Source |
|-----|--------|
| 0 | system control |
| 1 | external line 0 |
| 2 | external line 1 |
| 3 | independent watchdog |
| 4 | window watchdog |
| 5 | timer 0 |
| 6 | timer 1 |
| 7 | UART 0 |
| 8 | UART 1 |
| 9 | UART 2 |
| 10 | GPIO 0 |
| 11 | GPIO 1 |
| 12 | GPIO 2 |
| 13 | audio serial interface |
| 14 | voltage detector |
| 15 | reserved |
| 16 | ADC |

Top module: `wake_ctrl`

## Requirements
- R1: After reset the mask word (address 0x0) and the cause word (address 0x4) both read 0, and `wake_req_o` is low.
- R2: A write to address 0x0 stores the mask. Bit 15 and bits 31:17 are reserved: they ignore written data and always read 0, in both the mask and the cause word.
- R3: `wake_req_o` is high in the same cycle whenever the CPU is asleep and at least one source has both its interrupt bit and its mask bit at 1. It is low in every other case.
- R4: While both sleep inputs are low, `wake_req_o` stays low and the cause word does not gain bits, whatever the interrupt and mask values are.
- R5: On a clock edge where `wake_req_o` is high, every source whose interrupt and mask are both 1 gets its cause bit set. The new value is visible from the next cycle. Sources that are active but masked are not recorded.
- R6: Cause bits are sticky. They stay set after the interrupt drops and after the CPU wakes, until software clears them.
- R7: A write to address 0x4 clears every cause bit whose write-data bit is 1. Bits written with 0 are left unchanged.
- R8: If a capture and a clear hit the same cause bit on the same edge, the bit ends up set.
- R9: Address 0x8 reads back the light-sleep input on bit 3 and the deep-sleep input on bit 4. All other bits of that word read 0.
- R10: Writes to address 0x8 and to unmapped addresses change no state. Reads from unmapped addresses return 0.
- R11: Deep sleep alone, with the light-sleep input low, is enough to issue a wake request and capture its cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 17 | Peripheral interrupt lines, one per source slot |
| cpu_sleep_i | input | 1 | CPU reports light sleep |
| cpu_deep_i | input | 1 | CPU reports deep sleep |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| wake_req_o | output | 1 | Wake request to the power controller |

## Verification
The bench targets four cases.

- Masked-but-active sources during sleep: a design that skipped the mask would wake the system and record causes that software never enabled.
- Clears that land on the same edge as a fresh capture: a design that let the clear win would lose a wake cause.
- Deep sleep with the light-sleep flag low: a design that looked at only one flag would never wake from that state.
- Writes of all ones: a design that stored reserved bit 15 or the upper bits would read back nonzero there. The bench also writes to the read-only and unmapped addresses; a design that decoded too few address bits would alias those writes onto the mask or the cause word.

// File: rtl/wake_ctrl.sv
module wake_ctrl #(
  parameter int SRC_N = 17,
  parameter int AW = 4,
  parameter int DW = 32,
  parameter logic [SRC_N-1:0] SRC_VALID = 17'h17FFF,
  parameter int SLEEP_BIT = 3,
  parameter int DEEP_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] irq_i,
  input  logic             cpu_sleep_i,
  input  logic             cpu_deep_i,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             wake_req_o
);
  localparam logic [AW-1:0] MASK_ADDR  = AW'(0);
  localparam logic [AW-1:0] CAUSE_ADDR = AW'(4);
  localparam logic [AW-1:0] CPU_ADDR   = AW'(8);

  logic [SRC_N-1:0] mask_q, cause_q, hit, capture, clr;
  logic             asleep, wr_mask, wr_cause;
  logic             unused_wdata;

  assign wr_mask    = bus_sel & bus_wr & (bus_addr == MASK_ADDR);
  assign wr_cause   = bus_sel & bus_wr & (bus_addr == CAUSE_ADDR);
  assign hit        = irq_i & mask_q;
  assign asleep     = cpu_sleep_i | cpu_deep_i;
  assign wake_req_o = asleep & (|hit);
  assign capture    = wake_req_o ? hit : '0;
  assign clr        = wr_cause ? bus_wdata[SRC_N-1:0] : '0;
  assign unused_wdata = ^bus_wdata[DW-1:SRC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      cause_q <= '0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata[SRC_N-1:0] & SRC_VALID;
      cause_q <= ((cause_q & ~clr) | capture) & SRC_VALID;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      MASK_ADDR:  bus_rdata[SRC_N-1:0] = mask_q;
      CAUSE_ADDR: bus_rdata[SRC_N-1:0] = cause_q;
      CPU_ADDR: begin
        bus_rdata[SLEEP_BIT] = cpu_sleep_i;
        bus_rdata[DEEP_BIT]  = cpu_deep_i;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wake_ctrl_chk.sv
module wake_ctrl_chk #(
  parameter int SRC_N = 17,
  parameter int AW = 4,
  parameter logic [SRC_N-1:0] SRC_VALID = 17'h17FFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_N-1:0] irq_i,
  input logic             cpu_sleep_i,
  input logic             cpu_deep_i,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic             wake_req_o,
  input logic [SRC_N-1:0] mask_q,
  input logic [SRC_N-1:0] cause_q
);
  logic cause_wr;
  assign cause_wr = bus_sel && bus_wr && (bus_addr == AW'(4));

  // R3
  wake_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> (cpu_sleep_i || cpu_deep_i));

  // R4
  awake_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_sleep_i && !cpu_deep_i && !cause_wr) |=> $stable(cause_q));

  // R5
  wake_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |=> ((cause_q & $past(irq_i & mask_q)) == $past(irq_i & mask_q)));

  // R6
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((mask_q | cause_q) & ~SRC_VALID) == '0));
endmodule

bind wake_ctrl wake_ctrl_chk #(.SRC_N(SRC_N), .AW(AW), .SRC_VALID(SRC_VALID)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .cpu_sleep_i(cpu_sleep_i),
  .cpu_deep_i(cpu_deep_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .wake_req_o(wake_req_o), .mask_q(mask_q), .cause_q(cause_q)
);

// File: tb/wake_ctrl_tb_top.sv
module wake_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] VALID = 17'h17FFF;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [16:0] irq = '0;
  logic        sl = 1'b0, dp = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake;

  logic [16:0] m_mask = '0, m_cause = '0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .cpu_sleep_i(sl), .cpu_deep_i(dp),
    .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .wake_req_o(wake)
  );

  function automatic logic exp_wake();
    return (sl | dp) & (|(irq & m_mask));
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a)
      4'h0: return {15'd0, m_mask};
      4'h4: return {15'd0, m_cause};
      4'h8: return {27'd0, dp, sl, 3'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, logic [3:0] a);
    logic [3:0] sa = addr;
    logic ss = sel, sw = wr;
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 check(tag, rdata, exp_read(a));
    sel = ss; wr = sw; addr = sa;
  endtask

  task automatic step(string tag);
    logic [16:0] nc, clr;
    #1 check(tag, {31'd0, wake}, {31'd0, exp_wake()});
    clr = (sel && wr && addr == 4'h4) ? wdata[16:0] : '0;
    nc  = (m_cause & ~clr) | (exp_wake() ? (irq & m_mask) : '0);
    @(posedge clk);
    if (sel && wr && addr == 4'h0) m_mask = wdata[16:0] & VALID;
    m_cause = nc & VALID;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d, string tag);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 mask", 4'h0);
    rd("R1 cause", 4'h4);
    #1 check("R1 wake", {31'd0, wake}, 32'd0);
    // R2 reserved bits drop
    wr_reg(4'h0, 32'hFFFF_FFFF, "R2 wr");
    rd("R2 mask all-ones", 4'h0);
    check("R2 literal", exp_read(4'h0), 32'h0001_7FFF);
    // R4 awake, nothing happens
    irq = '1; step("R4 awake wake");
    rd("R4 awake cause", 4'h4);
    // R5 masked source not recorded
    wr_reg(4'h0, 32'h0001_0020, "R5 mask");
    irq = 17'h00028; sl = 1'b1;
    step("R3 wake sleep");
    rd("R5 cause", 4'h4);
    check("R5 literal", exp_read(4'h4), 32'h20);
    // R6 sticky
    irq = '0; sl = 1'b0; step("R6 idle");
    rd("R6 cause kept", 4'h4);
    // R11 deep only
    dp = 1'b1; irq = 17'h10000; step("R11 deep wake");
    rd("R11 cause", 4'h4);
    // R9 cpu word
    dp = 1'b0; irq = '0; sl = 1'b1; rd("R9 sleep", 4'h8);
    sl = 1'b0; dp = 1'b1; rd("R9 deep", 4'h8);
    dp = 1'b0;
    // R7 W1C
    wr_reg(4'h4, 32'h0000_0020, "R7 clear");
    rd("R7 cause", 4'h4);
    check("R7 literal", exp_read(4'h4), 32'h10000);
    // R8 capture beats clear
    sl = 1'b1; irq = 17'h10000;
    wr_reg(4'h4, 32'h0001_0000, "R8 wake");
    rd("R8 cause", 4'h4);
    check("R8 literal", exp_read(4'h4), 32'h10000);
    sl = 1'b0; irq = '0;
    // R10 read-only and unmapped writes
    wr_reg(4'h8, 32'hFFFF_FFFF, "R10 wr cpu");
    wr_reg(4'hC, 32'hFFFF_FFFF, "R10 wr unmapped");
    rd("R10 mask", 4'h0);
    rd("R10 cause", 4'h4);
    rd("R10 unmapped read", 4'hC);
    // random mix
    for (int i = 0; i < 400; i++) begin
      irq = 17'($urandom);
      if ($urandom % 3 == 0) irq = '0;
      sl = ($urandom % 3) == 0;
      dp = ($urandom % 4) == 0;
      sel = ($urandom % 2) == 1;
      wr = ($urandom % 3) != 0;
      addr = 4'(($urandom % 4) * 4);
      wdata = $urandom;
      step("R3 R5 R7 random");
      rd("R2 R6 random mask", 4'h0);
      rd("R5 R8 random cause", 4'h4);
      rd("R9 random cpu", 4'h8);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule